// File: doc/BRIEF.md
# Burst-Mode and Shutdown Supervisor

This block decides whether a resonant half-bridge controller may switch. It takes digitised condition flags (standby level comparator pair, line-good, line clamp/over-voltage, latched-disable trip, supply undervoltage and a shutdown request from the overcurrent sequencer), resynchronises each one through a two-flop synchroniser, and resolves them into one supervisor state. Four outputs come from that state: a run enable for the drive sequencer, a request to discharge the soft-start network, a low-consumption indication and an active-low open-drain enable for stopping the power-factor pre-regulator.

Stop causes are ranked. Supply undervoltage wins and also clears any fault latch. Latched faults (disable trip, second-level overcurrent latch) come next and hold until undervoltage. Line faults stop switching without latching. Burst idle has the lowest rank and is the only stop that keeps the soft-start charge, so switching resumes without a new soft-start. Burst entry uses the low comparator and exit needs the high comparator, which gives the hysteresis band.

Top module: `burst_shutdown_sup`

## Requirements
- R1: Every condition input passes through SYNC_STAGES (default 2) flops; a change at an input reaches the outputs SYNC_STAGES+1 clock edges later (one more for the state register).
- R2: After reset, and whenever the synchronised undervoltage flag is high, the state is UVLO: run low, soft-start discharge high, quiescent high, PFC stop pin released (pfc_stop_pull_n = 1).
- R3: A synchronised disable trip while not in undervoltage enters the latched fault state; it persists after the trip input falls and is cleared only by undervoltage.
- R4: A synchronised overcurrent shutdown request with its latch flag high also enters the latched fault state with the same clearing rule; without the latch flag it acts as a non-latched stop that ends when the request falls.
- R5: Line below threshold (line_ok low) stops switching without latching, asserts soft-start discharge and leaves the PFC stop pin released; operation resumes when line_ok returns.
- R6: Line over-voltage stops switching without latching, asserts soft-start discharge and pulls the PFC stop pin low (pfc_stop_pull_n = 0); switching restarts when it clears.
- R7: While running, a synchronised standby-low flag enters burst idle: run low, soft-start discharge low, quiescent high, PFC stop pin pulled low.
- R8: Burst idle is left only when the standby-high flag is set; the standby-low flag falling alone does not resume switching.
- R9: Priority is undervoltage, then latched faults, then line faults (over-voltage before undervoltage), then overcurrent stop, then burst idle; exactly one state is active.
- R10: Every stop state other than burst idle asserts soft-start discharge; the run state asserts none of discharge, quiescent or PFC stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stby_lo_i | input | 1 | Standby level below burst entry threshold |
| stby_hi_i | input | 1 | Standby level above burst exit threshold |
| line_ok_i | input | 1 | Line above brownout threshold |
| line_ov_i | input | 1 | Line at over-voltage clamp |
| dis_trip_i | input | 1 | Latched-disable comparator trip |
| uvlo_i | input | 1 | Supply undervoltage |
| ocp_stop_i | input | 1 | Stop request from overcurrent sequencer |
| ocp_latch_i | input | 1 | Overcurrent stop is the latching second level |
| run_o | output | 1 | Switching allowed |
| ss_discharge_o | output | 1 | Discharge soft-start |
| quiescent_o | output | 1 | Low-consumption mode |
| pfc_stop_pull_n_o | output | 1 | 0 = pull PFC stop pin low, 1 = released |
| state_o | output | 3 | Supervisor state code |

## Verification
The bench builds the block with the default two synchroniser stages, so every stimulus reaches the outputs three edges after it is driven and the bench samples at a fixed four-cycle settle point. With that depth the whole state space is reachable in short directed runs: burst entry and hysteretic exit, the disable and overcurrent latches that survive their inputs falling, the clearing by undervoltage, and overlapping causes that show the ranking.

// File: rtl/burst_sup_pkg.sv
package burst_sup_pkg;

    typedef enum logic [2:0] {
        ST_UVLO    = 3'd0,
        ST_LATCHED = 3'd1,
        ST_LINE_OV = 3'd2,
        ST_LINE_UV = 3'd3,
        ST_OCP     = 3'd4,
        ST_BURST   = 3'd5,
        ST_RUN     = 3'd6
    } sup_state_e;

    typedef struct packed {
        logic stby_lo;
        logic stby_hi;
        logic line_ok;
        logic line_ov;
        logic dis_trip;
        logic uvlo;
        logic ocp_stop;
        logic ocp_latch;
    } cond_t;

    localparam int COND_W = $bits(cond_t);

    typedef struct packed {
        logic run;
        logic ss_dis;
        logic quiet;
        logic pfc_pull_n;
    } sup_out_t;

    function automatic sup_out_t decode_outputs(sup_state_e s);
        sup_out_t o;
        o = '{run: 1'b0, ss_dis: 1'b1, quiet: 1'b1, pfc_pull_n: 1'b1};
        case (s)
            ST_UVLO:    o = '{run: 1'b0, ss_dis: 1'b1, quiet: 1'b1, pfc_pull_n: 1'b1};
            ST_LATCHED: o = '{run: 1'b0, ss_dis: 1'b1, quiet: 1'b1, pfc_pull_n: 1'b0};
            ST_LINE_OV: o = '{run: 1'b0, ss_dis: 1'b1, quiet: 1'b1, pfc_pull_n: 1'b0};
            ST_LINE_UV: o = '{run: 1'b0, ss_dis: 1'b1, quiet: 1'b1, pfc_pull_n: 1'b1};
            ST_OCP:     o = '{run: 1'b0, ss_dis: 1'b1, quiet: 1'b0, pfc_pull_n: 1'b0};
            ST_BURST:   o = '{run: 1'b0, ss_dis: 1'b0, quiet: 1'b1, pfc_pull_n: 1'b0};
            ST_RUN:     o = '{run: 1'b1, ss_dis: 1'b0, quiet: 1'b0, pfc_pull_n: 1'b1};
            default:    o = '{run: 1'b0, ss_dis: 1'b1, quiet: 1'b1, pfc_pull_n: 1'b1};
        endcase
        return o;
    endfunction

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] rst_val,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= rst_val;
        else     chain[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[i] <= rst_val;
            else     chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sup_latch.sv
module sup_latch (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst || clr_i) q <= 1'b0;
        else if (set_i)   q <= 1'b1;
    end
endmodule

// File: rtl/sup_fsm.sv
module sup_fsm
    import burst_sup_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cond_t      c,
    input  logic       latched,
    output sup_state_e state
);
    sup_state_e nxt;

    always_comb begin
        if (c.uvlo)                     nxt = ST_UVLO;
        else if (latched)               nxt = ST_LATCHED;
        else if (c.line_ov)             nxt = ST_LINE_OV;
        else if (!c.line_ok)            nxt = ST_LINE_UV;
        else if (c.ocp_stop)            nxt = ST_OCP;
        else if (state == ST_BURST)     nxt = c.stby_hi ? ST_RUN : ST_BURST;
        else if (c.stby_lo)             nxt = ST_BURST;
        else                            nxt = ST_RUN;
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_UVLO;
        else     state <= nxt;
    end
endmodule

// File: rtl/burst_shutdown_sup.sv
module burst_shutdown_sup
    import burst_sup_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       stby_lo_i,
    input  logic       stby_hi_i,
    input  logic       line_ok_i,
    input  logic       line_ov_i,
    input  logic       dis_trip_i,
    input  logic       uvlo_i,
    input  logic       ocp_stop_i,
    input  logic       ocp_latch_i,
    output logic       run_o,
    output logic       ss_discharge_o,
    output logic       quiescent_o,
    output logic       pfc_stop_pull_n_o,
    output logic [2:0] state_o
);
    cond_t raw, syn, rstv;
    logic  set_latch, latched;
    sup_state_e st;
    sup_out_t   o;

    always_comb begin
        raw = '{stby_lo: stby_lo_i, stby_hi: stby_hi_i, line_ok: line_ok_i,
                line_ov: line_ov_i, dis_trip: dis_trip_i, uvlo: uvlo_i,
                ocp_stop: ocp_stop_i, ocp_latch: ocp_latch_i};
        rstv = '0;
        rstv.uvlo = 1'b1;
    end

    sup_sync #(.WIDTH(COND_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .rst_val(rstv), .d(raw), .q(syn)
    );

    assign set_latch = syn.dis_trip | (syn.ocp_stop & syn.ocp_latch);

    sup_latch u_latch (
        .clk(clk), .rst(rst), .set_i(set_latch & ~syn.uvlo),
        .clr_i(syn.uvlo), .q(latched)
    );

    sup_fsm u_fsm (
        .clk(clk), .rst(rst), .c(syn),
        .latched(latched | (set_latch & ~syn.uvlo)), .state(st)
    );

    assign o                 = decode_outputs(st);
    assign run_o             = o.run;
    assign ss_discharge_o    = o.ss_dis;
    assign quiescent_o       = o.quiet;
    assign pfc_stop_pull_n_o = o.pfc_pull_n;
    assign state_o           = st;
endmodule

// File: rtl/burst_shutdown_sup_chk.sv
module burst_shutdown_sup_chk (
    input logic       clk,
    input logic       rst,
    input logic       run_o,
    input logic       ss_discharge_o,
    input logic       quiescent_o,
    input logic       pfc_stop_pull_n_o,
    input logic [2:0] state_o
);
    // R10: run excludes every stop indication
    a_r10_run_clean: assert property (@(posedge clk) disable iff (rst)
        run_o |-> (!ss_discharge_o && !quiescent_o && pfc_stop_pull_n_o));
    // R7: burst idle keeps soft-start and pulls PFC stop
    a_r7_burst_outputs: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd5) |-> (!ss_discharge_o && !pfc_stop_pull_n_o && !run_o));
    // R3: latched state left only towards undervoltage
    a_r3_latch_exit: assert property (@(posedge clk) disable iff (rst)
        ($past(state_o) == 3'd1 && state_o != 3'd1) |-> (state_o == 3'd0));
    // R2: undervoltage releases PFC stop and discharges
    a_r2_uvlo_outputs: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd0) |-> (pfc_stop_pull_n_o && ss_discharge_o));
    // R10: any non-run non-burst state discharges soft-start
    a_r10_stop_discharge: assert property (@(posedge clk) disable iff (rst)
        (!run_o && state_o != 3'd5) |-> ss_discharge_o);
    // R9: state code always legal
    a_r9_legal_state: assert property (@(posedge clk) disable iff (rst)
        state_o <= 3'd6);
endmodule

bind burst_shutdown_sup burst_shutdown_sup_chk u_chk (
    .clk(clk), .rst(rst), .run_o(run_o), .ss_discharge_o(ss_discharge_o),
    .quiescent_o(quiescent_o), .pfc_stop_pull_n_o(pfc_stop_pull_n_o),
    .state_o(state_o)
);

// File: tb/burst_shutdown_sup_tb.sv
module burst_shutdown_sup_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stby_lo = 0, stby_hi = 1, line_ok = 1, line_ov = 0;
    logic dis_trip = 0, uvlo = 1, ocp_stop = 0, ocp_latch = 0;
    logic run, ssd, quiet, pfcn;
    logic [2:0] st;
    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    burst_shutdown_sup u_dut (
        .clk(clk), .rst(rst), .stby_lo_i(stby_lo), .stby_hi_i(stby_hi),
        .line_ok_i(line_ok), .line_ov_i(line_ov), .dis_trip_i(dis_trip),
        .uvlo_i(uvlo), .ocp_stop_i(ocp_stop), .ocp_latch_i(ocp_latch),
        .run_o(run), .ss_discharge_o(ssd), .quiescent_o(quiet),
        .pfc_stop_pull_n_o(pfcn), .state_o(st)
    );

    task automatic settle(int n = 4);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_out(string tag, logic r, logic s, logic q, logic p);
        n_chk++;
        if ({run, ssd, quiet, pfcn} !== {r, s, q, p}) begin
            n_bad++;
            $display("FAIL %s: run/ssd/quiet/pfc_n got %b%b%b%b exp %b%b%b%b",
                     tag, run, ssd, quiet, pfcn, r, s, q, p);
        end
    endtask

    task automatic t_reset();
        #1;
        expect_out("R2 reset", 0, 1, 1, 1);
        rst = 0;
        settle();
        expect_out("R2 uvlo held", 0, 1, 1, 1);
        uvlo = 0;
        settle();
        expect_out("R10 run", 1, 0, 0, 1);
    endtask

    task automatic t_latency();
        // R1: input change visible only after three edges
        line_ok = 0;
        @(posedge clk); @(posedge clk); #1;
        expect_out("R1 not yet", 1, 0, 0, 1);
        @(posedge clk); #1;
        expect_out("R1 arrived", 0, 1, 1, 1);
        line_ok = 1;
        settle();
    endtask

    task automatic t_burst();
        stby_hi = 0; stby_lo = 1;
        settle();
        expect_out("R7 burst entry", 0, 0, 1, 0);
        stby_lo = 0;
        settle();
        expect_out("R8 band holds idle", 0, 0, 1, 0);
        stby_hi = 1;
        settle();
        expect_out("R8 burst exit", 1, 0, 0, 1);
    endtask

    task automatic t_line();
        line_ok = 0;
        settle();
        expect_out("R5 line uv", 0, 1, 1, 1);
        line_ok = 1;
        settle();
        expect_out("R5 line resume", 1, 0, 0, 1);
        line_ov = 1;
        settle();
        expect_out("R6 line ov", 0, 1, 1, 0);
        line_ok = 0;
        settle();
        expect_out("R9 ov over uv", 0, 1, 1, 0);
        line_ov = 0; line_ok = 1;
        settle();
        expect_out("R6 ov resume", 1, 0, 0, 1);
    endtask

    task automatic t_dis_latch();
        dis_trip = 1;
        settle();
        expect_out("R3 dis trip", 0, 1, 1, 0);
        dis_trip = 0;
        settle();
        expect_out("R3 latch holds", 0, 1, 1, 0);
        line_ok = 0;
        settle();
        expect_out("R9 latch over line", 0, 1, 1, 0);
        line_ok = 1;
        uvlo = 1;
        settle();
        expect_out("R3 uvlo clears", 0, 1, 1, 1);
        uvlo = 0;
        settle();
        expect_out("R3 restart", 1, 0, 0, 1);
    endtask

    task automatic t_ocp();
        ocp_stop = 1; ocp_latch = 0;
        settle();
        expect_out("R4 ocp stop", 0, 1, 0, 0);
        ocp_stop = 0;
        settle();
        expect_out("R4 ocp release", 1, 0, 0, 1);
        ocp_stop = 1; ocp_latch = 1;
        settle();
        ocp_stop = 0; ocp_latch = 0;
        settle();
        expect_out("R4 ocp latch holds", 0, 1, 1, 0);
        uvlo = 1;
        settle();
        uvlo = 0;
        settle();
        expect_out("R4 cleared by uvlo", 1, 0, 0, 1);
    endtask

    task automatic t_priority();
        stby_lo = 1; stby_hi = 0; line_ok = 0;
        settle();
        expect_out("R9 line over burst", 0, 1, 1, 1);
        dis_trip = 1; uvlo = 1;
        settle();
        expect_out("R9 uvlo over dis", 0, 1, 1, 1);
        uvlo = 0;
        settle();
        expect_out("R9 dis over line", 0, 1, 1, 0);
        dis_trip = 0;
        uvlo = 1;
        settle();
        uvlo = 0; line_ok = 1;
        settle();
        expect_out("R7 burst after restart", 0, 0, 1, 0);
    endtask

    initial begin
        t_reset();
        t_latency();
        t_burst();
        t_line();
        t_dis_latch();
        t_ocp();
        t_priority();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule